// File: doc/BRIEF.md
# Spectrum Magnitude Reorder and Rescale Stage

This stage follows a fixed-point spectrum magnitude unit. The magnitudes reach it as single-precision floats, one frame of 1024 samples at a time, in bit-reversed order. The stage changes the scale of each sample by editing only its exponent. Bin 0 gets a larger factor than the other bins. Each result is written into a frame buffer at its natural-order slot. Once the 1024th sample is stored, the stage reads the buffer out from slot 0 upward and presents each word on a registered FIFO write strobe.

A separate combinational path takes floats from the source FIFO, which span roughly plus or minus 16, and divides them by 16 using the same exponent arithmetic. The scaled word can therefore be used on the next clock. A three-state task handshake (idle, running, done) controls each frame. A start pulse launches a frame, and the done state means the last word has been written.

Top module: `fmag_reorder`

## Requirements
- R1: `task_state_o` encodes idle as 0, running as 1 and done as 2. Reset gives idle with `wr_o` low. A start pulse seen in idle or done gives running on the next cycle. A start pulse seen while running has no effect.
- R2: A magnitude is captured only when `mag_valid_i` is high during the capture phase of running. Strobes seen in idle, in done, or while the buffer drains are ignored.
- R3: Arrival number k (0..1023, counted in captured samples) is stored at the natural index formed by mirroring the 10 bits of k, so that bit 0 becomes bit 9. Output word j is therefore the sample that arrived as the mirror of j.
- R4: For every bin other than 0, the output has 4 added to its exponent field (bits 30:23). The sign (bit 31) and the mantissa (bits 22:0) are unchanged.
- R5: The bin at natural index 0, which is arrival 0, has 5 added to its exponent instead of 4.
- R6: In both paths, a word whose exponent field is 0 (zero or denormal) or 255 (infinity or NaN) passes through unchanged.
- R7: An upward adjustment that would go past 254 gives exponent 254, with sign and mantissa kept.
- R8: `in_scaled_o` is combinational. It equals `in_word_i` with 4 subtracted from the exponent. If that result falls below 1, the output is a signed zero: the sign is kept and all other bits are 0.
- R9: The drain starts after the 1024th capture. The first `wr_o` rises two clock edges after the edge that captured the last sample. After that come 1024 back-to-back strobes carrying natural indices 0 to 1023, and each data word is registered on the same edge as its strobe.
- R10: Exactly 1024 writes occur per task, all of them while running. Done appears on the cycle that follows the last strobe.
- R11: A start from done clears both counters. The next frame is captured from arrival 0 and drained from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Task start pulse |
| task_state_o | output | 2 | Task state: 0 idle, 1 running, 2 done |
| in_word_i | input | 32 | Float read from the source FIFO |
| in_scaled_o | output | 32 | Input float divided by 16 (combinational) |
| mag_valid_i | input | 1 | Magnitude sample strobe |
| mag_word_i | input | 32 | Magnitude sample as a float, bit-reversed order |
| wr_o | output | 1 | FIFO write strobe (registered) |
| wr_data_o | output | 32 | FIFO write data, natural order (registered) |

## Verification
The input scaler has no register, so it is checked one time unit after its input changes.

The frame path has more timing points, each counted against the edge that captured the 1024th sample:
- The first write strobe is due two edges after that edge.
- The last write strobe is due 1025 edges after it.
- Done is due 1026 edges after it.

The bench records the edge count at the capture edge and at every strobe it observes, and compares each with these targets. A scoreboard queue holds the expected words in natural order and is popped on each strobe. Any gap, any extra write or any late done therefore shows up at the exact cycle where it happens.

// File: rtl/fmag_pkg.sv
package fmag_pkg;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_RUN  = 2'd1,
    TS_DONE = 2'd2
  } task_st_e;

  typedef enum logic [1:0] {
    PH_CAP   = 2'd0,
    PH_DRAIN = 2'd1,
    PH_FLUSH = 2'd2
  } phase_e;

endpackage

// File: rtl/fmag_exp_scale.sv
module fmag_exp_scale #(
  parameter int DATA_W  = 32,
  parameter int EXP_W   = 8,
  parameter int DELTA_W = 8
) (
  input  logic [DATA_W-1:0]        word_i,
  input  logic signed [DELTA_W-1:0] delta_i,
  output logic [DATA_W-1:0]        word_o
);
  localparam int MAN_W   = DATA_W - 1 - EXP_W;
  localparam int SUM_W   = EXP_W + 2;
  localparam int EXP_TOP = (1 << EXP_W) - 2;
  localparam logic signed [SUM_W-1:0] TOP_S = SUM_W'(EXP_TOP);
  localparam logic signed [SUM_W-1:0] ONE_S = SUM_W'(1);

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;
  logic signed [SUM_W-1:0] d_ext;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sgn   = word_i[DATA_W-1];
    ex    = word_i[DATA_W-2 -: EXP_W];
    man   = word_i[MAN_W-1:0];
    d_ext = SUM_W'(delta_i);
    sum   = $signed({2'b00, ex}) + d_ext;
    if (ex == '0 || ex == '1) begin
      word_o = word_i;
    end else if (sum > TOP_S) begin
      word_o = {sgn, EXP_W'(EXP_TOP), man};
    end else if (sum < ONE_S) begin
      word_o = {sgn, {(DATA_W-1){1'b0}}};
    end else begin
      word_o = {sgn, sum[EXP_W-1:0], man};
    end
  end
endmodule

// File: rtl/fmag_frame_ram.sv
module fmag_frame_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/fmag_ctrl.sv
module fmag_ctrl
  import fmag_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic             last_wr_i,
  output task_st_e         state_o,
  output logic             cap_we_o,
  output logic [IDX_W-1:0] arr_idx_o,
  output logic [IDX_W-1:0] slot_o,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_addr_o,
  output logic             last_rd_o
);
  task_st_e         st;
  phase_e           ph;
  logic [IDX_W-1:0] arr_cnt;
  logic [IDX_W-1:0] rd_cnt;
  logic             take_start;

  assign take_start = start_i && (st != TS_RUN);
  assign cap_we_o   = (st == TS_RUN) && (ph == PH_CAP) && valid_i;
  assign rd_en_o    = (st == TS_RUN) && (ph == PH_DRAIN);
  assign last_rd_o  = rd_en_o && (rd_cnt == '1);
  assign arr_idx_o  = arr_cnt;
  assign rd_addr_o  = rd_cnt;
  assign state_o    = st;

  for (genvar i = 0; i < IDX_W; i++) begin : g_mirror
    assign slot_o[i] = arr_cnt[IDX_W-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= TS_IDLE;
      ph      <= PH_CAP;
      arr_cnt <= '0;
      rd_cnt  <= '0;
    end else begin
      case (st)
        TS_IDLE, TS_DONE: begin
          if (st == TS_IDLE) begin
            arr_cnt <= '0;
            rd_cnt  <= '0;
          end
          if (take_start) begin
            st      <= TS_RUN;
            ph      <= PH_CAP;
            arr_cnt <= '0;
            rd_cnt  <= '0;
          end
        end
        TS_RUN: begin
          case (ph)
            PH_CAP: begin
              if (valid_i) begin
                arr_cnt <= arr_cnt + 1'b1;
                if (arr_cnt == '1) ph <= PH_DRAIN;
              end
            end
            PH_DRAIN: begin
              rd_cnt <= rd_cnt + 1'b1;
              if (rd_cnt == '1) ph <= PH_FLUSH;
            end
            PH_FLUSH: begin
              if (last_wr_i) begin
                st <= TS_DONE;
                ph <= PH_CAP;
              end
            end
            default: ph <= PH_CAP;
          endcase
        end
        default: st <= TS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fmag_reorder.sv
module fmag_reorder
  import fmag_pkg::*;
#(
  parameter int IDX_W     = 10,
  parameter int DATA_W    = 32,
  parameter int EXP_W     = 8,
  parameter int OUT_SHIFT = 4,
  parameter int DC_SHIFT  = 5,
  parameter int IN_SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic [1:0]        task_state_o,
  input  logic [DATA_W-1:0] in_word_i,
  output logic [DATA_W-1:0] in_scaled_o,
  input  logic              mag_valid_i,
  input  logic [DATA_W-1:0] mag_word_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int DELTA_W = EXP_W;

  task_st_e          st;
  logic              cap_we;
  logic [IDX_W-1:0]  arr_idx;
  logic [IDX_W-1:0]  slot;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_addr;
  logic              last_rd;
  logic              rd_v1, last1, last2;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] mag_scaled;
  logic signed [DELTA_W-1:0] out_delta;
  logic signed [DELTA_W-1:0] in_delta;

  assign in_delta  = DELTA_W'(-IN_SHIFT);
  assign out_delta = (arr_idx == '0) ? DELTA_W'(DC_SHIFT) : DELTA_W'(OUT_SHIFT);

  fmag_exp_scale #(.DATA_W(DATA_W), .EXP_W(EXP_W), .DELTA_W(DELTA_W)) u_in_scale (
    .word_i (in_word_i),
    .delta_i(in_delta),
    .word_o (in_scaled_o)
  );

  fmag_exp_scale #(.DATA_W(DATA_W), .EXP_W(EXP_W), .DELTA_W(DELTA_W)) u_out_scale (
    .word_i (mag_word_i),
    .delta_i(out_delta),
    .word_o (mag_scaled)
  );

  fmag_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .valid_i  (mag_valid_i),
    .last_wr_i(wr_o && last2),
    .state_o  (st),
    .cap_we_o (cap_we),
    .arr_idx_o(arr_idx),
    .slot_o   (slot),
    .rd_en_o  (rd_en),
    .rd_addr_o(rd_addr),
    .last_rd_o(last_rd)
  );

  fmag_frame_ram #(.ADDR_W(IDX_W), .DATA_W(DATA_W)) u_ram (
    .clk    (clk),
    .we_i   (cap_we),
    .waddr_i(slot),
    .wdata_i(mag_scaled),
    .re_i   (rd_en),
    .raddr_i(rd_addr),
    .rdata_o(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v1     <= 1'b0;
      last1     <= 1'b0;
      last2     <= 1'b0;
      wr_o      <= 1'b0;
      wr_data_o <= '0;
    end else begin
      rd_v1 <= rd_en;
      last1 <= last_rd;
      last2 <= last1;
      wr_o  <= rd_v1;
      if (rd_v1) wr_data_o <= ram_q;
    end
  end

  assign task_state_o = st;
endmodule

// File: rtl/fmag_reorder_chk.sv
module fmag_reorder_chk #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [1:0]        task_state_o,
  input logic [DATA_W-1:0] in_word_i,
  input logic [DATA_W-1:0] in_scaled_o,
  input logic              wr_o
);
  localparam int FRAME = 1 << IDX_W;
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_RUN  = 2'd1;
  localparam logic [1:0] S_DONE = 2'd2;

  logic [IDX_W:0]   wcnt;
  logic [EXP_W-1:0] in_exp;
  assign in_exp = in_word_i[DATA_W-2 -: EXP_W];

  always_ff @(posedge clk) begin
    if (rst) wcnt <= '0;
    else if (start_i && task_state_o != S_RUN) wcnt <= '0;
    else if (wr_o) wcnt <= wcnt + 1'b1;
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (start_i && task_state_o != S_RUN) |=> task_state_o == S_RUN); // R1
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (task_state_o == S_DONE && !start_i) |=> task_state_o == S_DONE); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (task_state_o == S_IDLE && !start_i) |=> task_state_o == S_IDLE); // R1
  AST_WR_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
    wr_o |-> task_state_o == S_RUN); // R10
  AST_STROBE_END_DONE: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_o) && !wr_o) |-> task_state_o == S_DONE); // R9
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (task_state_o == S_DONE && $past(task_state_o) == S_RUN) |-> ($past(wr_o) && wcnt == (IDX_W+1)'(FRAME))); // R10
  AST_IN_SPECIAL_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_exp == '0 || in_exp == '1) |-> in_scaled_o == in_word_i); // R6
  AST_IN_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    in_scaled_o[DATA_W-1] == in_word_i[DATA_W-1]); // R8
endmodule

bind fmag_reorder fmag_reorder_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .EXP_W(EXP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .task_state_o(task_state_o),
  .in_word_i   (in_word_i),
  .in_scaled_o (in_scaled_o),
  .wr_o        (wr_o)
);

// File: tb/fmag_reorder_tb_top.sv
module fmag_reorder_tb_top;
  localparam int N = 1024;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [1:0]  task_state_o;
  logic [31:0] in_word_i;
  logic [31:0] in_scaled_o;
  logic        mag_valid_i;
  logic [31:0] mag_word_i;
  logic        wr_o;
  logic [31:0] wr_data_o;

  fmag_reorder dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .task_state_o(task_state_o),
    .in_word_i(in_word_i), .in_scaled_o(in_scaled_o),
    .mag_valid_i(mag_valid_i), .mag_word_i(mag_word_i),
    .wr_o(wr_o), .wr_data_o(wr_data_o)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int mirror(int k);
    int r = 0;
    for (int b = 0; b < 10; b++) if (k[b]) r |= (1 << (9 - b));
    return r;
  endfunction

  function automatic logic [31:0] ref_scale(logic [31:0] w, int d);
    int e = int'(w[30:23]);
    if (e == 0 || e == 255) return w;
    e = e + d;
    if (e > 254) e = 254;
    if (e < 1) return {w[31], 31'b0};
    return {w[31], 8'(e), w[22:0]};
  endfunction

  function automatic logic [31:0] mag_word(int k, int s);
    int e;
    int m;
    if (k == 0) e = (s == 1) ? 130 : 0;
    else if (k % 9 == 0) e = 0;
    else if (k % 9 == 4) e = 251 + (k % 4);
    else if (k % 9 == 7) e = 255;
    else e = 60 + ((k * s * 7) % 120);
    m = (k * 40503 + s * 977) & 32'h7FFFFF;
    return {1'b0, 8'(e), 23'(m)};
  endfunction

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int wr_seen = 0;
  int first_wr = 0;
  int last_wr = 0;
  int gaps = 0;

  always @(negedge clk) begin
    if (!rst && wr_o) begin
      if (wr_seen == 0) first_wr = cyc;
      else if (cyc != last_wr + 1) gaps++;
      last_wr = cyc;
      wr_seen++;
      if (exp_q.size() == 0) begin
        n_chk++;
        n_err++;
        $display("FAIL R10 extra write: actual=%h expected=none", wr_data_o);
      end else begin
        chk(tag_q.pop_front(), wr_data_o, exp_q.pop_front());
      end
    end
  end

  task automatic drive_frame(int s, bit use_gaps, output int last_edge);
    logic [31:0] nat [N];
    string       tg  [N];
    for (int k = 0; k < N; k++) begin
      logic [31:0] w;
      int j;
      if (use_gaps && (k % 7 == 3)) begin
        @(negedge clk);
        mag_valid_i = 1'b0;
        mag_word_i  = 32'hFFFF_0000;
      end
      @(negedge clk);
      if (k == 501) begin
        chk("R1 start while running ignored", 32'(task_state_o), 32'd1);
        start_i = 1'b0;
      end
      if (k == 500) start_i = 1'b1;
      w = mag_word(k, s);
      mag_valid_i = 1'b1;
      mag_word_i  = w;
      j = mirror(k);
      nat[j] = ref_scale(w, (k == 0) ? 5 : 4);
      if (k == 0) tg[j] = $sformatf("R5 DC bin frame%0d", s);
      else if (w[30:23] == 8'd0 || w[30:23] == 8'd255) tg[j] = $sformatf("R6 special exp idx %0d", j);
      else if (w[30:23] >= 8'd251) tg[j] = $sformatf("R7 saturate idx %0d", j);
      else tg[j] = $sformatf("R3 R4 idx %0d", j);
    end
    @(negedge clk);
    mag_valid_i = 1'b0;
    last_edge = cyc;
    for (int j = 0; j < N; j++) begin
      exp_q.push_back(nat[j]);
      tag_q.push_back(tg[j]);
    end
  endtask

  task automatic wait_done(output int done_cyc);
    done_cyc = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (task_state_o == 2'd2) begin
        done_cyc = cyc;
        break;
      end
    end
  endtask

  task automatic frame_checks(string fr, int L, int done_cyc);
    chk({"R9 first strobe ", fr}, 32'(first_wr), 32'(L + 2));
    chk({"R9 last strobe ", fr}, 32'(last_wr), 32'(L + 1025));
    chk({"R9 no gaps ", fr}, 32'(gaps), 32'd0);
    chk({"R10 write count ", fr}, 32'(wr_seen), 32'(N));
    chk({"R10 done timing ", fr}, 32'(done_cyc), 32'(L + 1026));
    chk({"R10 queue drained ", fr}, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int L;
    int dc;
    rst = 1'b1;
    start_i = 1'b0;
    in_word_i = '0;
    mag_valid_i = 1'b0;
    mag_word_i = '0;
    repeat (5) @(negedge clk);
    chk("R1 reset state", 32'(task_state_o), 32'd0);
    chk("R1 reset strobe", 32'(wr_o), 32'd0);
    rst = 1'b0;

    // input scaler, combinational
    in_word_i = 32'h4180_0000; #1 chk("R8 16.0 to 1.0", in_scaled_o, 32'h3F80_0000);
    in_word_i = 32'hC100_0000; #1 chk("R8 -8.0 to -0.5", in_scaled_o, 32'hBF00_0000);
    in_word_i = 32'h0280_0000; #1 chk("R8 exp5 to exp1", in_scaled_o, 32'h0080_0000);
    in_word_i = 32'h0180_0000; #1 chk("R8 underflow to zero", in_scaled_o, 32'h0000_0000);
    in_word_i = 32'h8200_0000; #1 chk("R8 underflow keeps sign", in_scaled_o, 32'h8000_0000);
    in_word_i = 32'h0000_0123; #1 chk("R6 input denormal", in_scaled_o, 32'h0000_0123);
    in_word_i = 32'h7F80_0000; #1 chk("R6 input infinity", in_scaled_o, 32'h7F80_0000);

    // strobes in idle are ignored
    repeat (4) begin
      @(negedge clk);
      mag_valid_i = 1'b1;
      mag_word_i = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    mag_valid_i = 1'b0;
    chk("R2 idle strobes ignored state", 32'(task_state_o), 32'd0);
    chk("R2 idle strobes no write", 32'(wr_seen), 32'd0);

    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R1 start from idle", 32'(task_state_o), 32'd1);

    drive_frame(1, 1'b0, L);
    repeat (40) begin
      @(negedge clk);
      mag_valid_i = 1'b1;
      mag_word_i = 32'h1234_5678;
    end
    mag_valid_i = 1'b0;
    wait_done(dc);
    frame_checks("frame1", L, dc);

    // done state ignores strobes and holds
    repeat (20) begin
      @(negedge clk);
      mag_valid_i = 1'b1;
      mag_word_i = 32'h4000_0000;
    end
    @(negedge clk);
    mag_valid_i = 1'b0;
    chk("R2 done strobes no write", 32'(wr_seen), 32'(N));
    chk("R1 done holds", 32'(task_state_o), 32'd2);

    wr_seen = 0;
    gaps = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 start from done", 32'(task_state_o), 32'd1);
    drive_frame(2, 1'b1, L);
    wait_done(dc);
    frame_checks("R11 frame2", L, dc);

    summary();
    $finish;
  end
endmodule